// File: doc/BRIEF.md
# Multi-Channel System Counter Timer

This block keeps a free-running 64-bit physical count that advances by one on every cycle in which the tick input is high. A virtual count is presented alongside it: the physical count less a programmable offset. Five down-counting channels share the same tick. Each channel has a 32-bit remaining-time register, and each is bound to a fixed interrupt identifier. The channels, by index, are:

- 0: low-privilege physical
- 1: hypervisor physical
- 2: secure physical
- 3: low-privilege virtual
- 4: hypervisor virtual

When a channel's remaining time steps down onto zero, the channel emits a one-cycle interrupt pulse. The identifier value 0x3FF marks a channel that has no interrupt line. Such a channel never pulses.

Software loads the channel registers and the virtual offset through a small write port. The port uses a valid/ready handshake. Ready is permanently high, so a write is taken in every cycle in which valid is high, and the port never applies back-pressure. The tick input and the outputs are plain level signals.

Top module: `sys_count_timer`

## Requirements
- R1: A synchronous reset (rst high at a clock edge) clears the physical count, the virtual offset and every channel's remaining time to zero, and drives all irq bits low.
- R2: In each cycle with tick high, phys_cnt increases by exactly one at the next edge. In each cycle with tick low, phys_cnt holds its value.
- R3: virt_cnt always equals phys_cnt minus the virtual offset, modulo 2^64. A write with wr_sel = 5 replaces the offset with wr_data, and the new offset takes effect after that edge.
- R4: A write with wr_sel = c (c in 0..4) loads wr_data[31:0] into the remaining time of channel c. Every tick then lowers that value by one.
- R5: The irq[c] pulse is high for exactly one cycle. It appears in the cycle after the tick edge that takes channel c from 1 to 0. A channel loaded with N (N ≥ 1) therefore pulses after exactly N ticks.
- R6: A tick on a channel whose remaining time is zero wraps the value to 0xFFFF_FFFF and raises no interrupt.
- R7: When a channel write and a tick fall in the same cycle, the write wins. The written value is loaded undecremented, and no pulse arises from that cycle.
- R8: irq_id[c*10 +: 10] carries channel c's fixed identifier. By channel index 0..4, the identifiers are 13, 10, 0x3FF, 11 and 0x3FF.
- R9: A channel whose identifier is 0x3FF (channels 2 and 4) never raises its irq bit.
- R10: wr_ready is always high. A write with wr_sel of 6 or 7 changes neither the offset nor any channel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tick | input | 1 | Count enable for this cycle |
| wr_valid | input | 1 | Write request |
| wr_ready | output | 1 | Write accepted (always high) |
| wr_sel | input | 3 | Target: 0..4 channel, 5 virtual offset |
| wr_data | input | 64 | Write value (channels use bits 31:0) |
| phys_cnt | output | 64 | Physical count |
| virt_cnt | output | 64 | Physical count minus offset |
| irq | output | 5 | Per-channel interrupt pulses |
| irq_id | output | 50 | Packed fixed identifiers, 10 bits per channel |

## Verification
A channel write and a tick can land in the same cycle. The bench provokes this by first loading a channel with 1, which would make the next tick fire, and then presenting a tick together with a write of 3. It judges the outcome by the absence of a pulse in that cycle and by a pulse arriving exactly three ticks later. An offset write is likewise paired with a tick, and the virtual count is checked against both the incremented physical count and the new offset. Sweeps over every channel and several load values check that pulse timing is exact, and that channels without a line stay silent.

// File: rtl/sct_pkg.sv
package sct_pkg;
  localparam int NO_LINE_ID = 'h3FF;

  // fixed interrupt identifier per channel index
  function automatic int chan_irq_id(input int ch);
    case (ch)
      0:       return 13;
      1:       return 10;
      3:       return 11;
      default: return NO_LINE_ID;
    endcase
  endfunction
endpackage

// File: rtl/sct_count_core.sv
module sct_count_core #(
  parameter int CNT_W = 64
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             off_ld,
  input  logic [CNT_W-1:0] off_val,
  output logic [CNT_W-1:0] phys,
  output logic [CNT_W-1:0] virt
);
  localparam logic [CNT_W-1:0] STEP = CNT_W'(1);

  logic [CNT_W-1:0] phys_q;
  logic [CNT_W-1:0] off_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      phys_q <= '0;
      off_q  <= '0;
    end else begin
      if (tick)   phys_q <= phys_q + STEP;
      if (off_ld) off_q  <= off_val;
    end
  end

  assign phys = phys_q;
  assign virt = phys_q - off_q;

  AST_PHYS_STEP: assert property (@(posedge clk) disable iff (rst)
    tick |=> phys == $past(phys) + STEP); // R2
  AST_PHYS_HOLD: assert property (@(posedge clk) disable iff (rst)
    !tick |=> $stable(phys)); // R2
  AST_VIRT_NEW_OFFSET: assert property (@(posedge clk) disable iff (rst)
    (off_ld && !tick) |=> virt == $past(phys) - $past(off_val)); // R3
endmodule

// File: rtl/sct_channel.sv
module sct_channel #(
  parameter int TV_W   = 32,
  parameter int IRQ_ID = 13
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            tick,
  input  logic            ld,
  input  logic [TV_W-1:0] ld_val,
  output logic            irq
);
  localparam logic [TV_W-1:0] ONE = TV_W'(1);

  logic [TV_W-1:0] tv_q;

  always_ff @(posedge clk) begin
    if (rst)       tv_q <= '0;
    else if (ld)   tv_q <= ld_val;
    else if (tick) tv_q <= tv_q - ONE;
  end

  generate
    if (IRQ_ID != sct_pkg::NO_LINE_ID) begin : g_line
      logic irq_q;
      always_ff @(posedge clk) begin
        if (rst) irq_q <= 1'b0;
        else     irq_q <= tick && !ld && (tv_q == ONE);
      end
      assign irq = irq_q;
    end else begin : g_noline
      assign irq = 1'b0;
    end
  endgenerate

  AST_DECREMENT: assert property (@(posedge clk) disable iff (rst)
    (tick && !ld) |=> tv_q == $past(tv_q) - ONE); // R4
  AST_LOAD_WINS: assert property (@(posedge clk) disable iff (rst)
    ld |=> tv_q == $past(ld_val)); // R7
  AST_IRQ_AT_ZERO: assert property (@(posedge clk) disable iff (rst)
    irq |-> tv_q == '0); // R5
  AST_IRQ_PULSE: assert property (@(posedge clk) disable iff (rst)
    irq |=> !irq); // R5
  AST_WRAP_QUIET: assert property (@(posedge clk) disable iff (rst)
    (tick && !ld && tv_q == '0) |=> !irq); // R6
endmodule

// File: rtl/sys_count_timer.sv
module sys_count_timer #(
  parameter int CNT_W = 64,
  parameter int TV_W  = 32,
  parameter int NCH   = 5,
  parameter int ID_W  = 10,
  parameter int SEL_W = $clog2(NCH + 1)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                tick,
  input  logic                wr_valid,
  output logic                wr_ready,
  input  logic [SEL_W-1:0]    wr_sel,
  input  logic [CNT_W-1:0]    wr_data,
  output logic [CNT_W-1:0]    phys_cnt,
  output logic [CNT_W-1:0]    virt_cnt,
  output logic [NCH-1:0]      irq,
  output logic [NCH*ID_W-1:0] irq_id
);
  localparam logic [SEL_W-1:0] SEL_OFFSET = SEL_W'(NCH);

  function automatic logic [NCH-1:0] noline_mask();
    logic [NCH-1:0] m;
    m = '0;
    for (int i = 0; i < NCH; i++)
      m[i] = (sct_pkg::chan_irq_id(i) == sct_pkg::NO_LINE_ID);
    return m;
  endfunction
  localparam logic [NCH-1:0] NOLINE = noline_mask();

  assign wr_ready = 1'b1;

  sct_count_core #(.CNT_W(CNT_W)) u_core (
    .clk     (clk),
    .rst     (rst),
    .tick    (tick),
    .off_ld  (wr_valid && (wr_sel == SEL_OFFSET)),
    .off_val (wr_data),
    .phys    (phys_cnt),
    .virt    (virt_cnt)
  );

  generate
    for (genvar c = 0; c < NCH; c++) begin : g_ch
      sct_channel #(
        .TV_W   (TV_W),
        .IRQ_ID (sct_pkg::chan_irq_id(c))
      ) u_ch (
        .clk    (clk),
        .rst    (rst),
        .tick   (tick),
        .ld     (wr_valid && (wr_sel == SEL_W'(c))),
        .ld_val (wr_data[TV_W-1:0]),
        .irq    (irq[c])
      );
      assign irq_id[c*ID_W +: ID_W] = ID_W'(sct_pkg::chan_irq_id(c));
    end
  endgenerate

  AST_NOLINE_SILENT: assert property (@(posedge clk) disable iff (rst)
    (irq & NOLINE) == '0); // R9
  AST_RESET_QUIET: assert property (@(posedge clk)
    rst |=> (irq == '0 && phys_cnt == '0)); // R1
endmodule

// File: tb/test_sys_count_timer.sv
module test_sys_count_timer;
  localparam int PERIOD = 10;
  localparam int NCH = 5;
  localparam int IDW = 10;

  logic clk = 1'b0;
  always #(PERIOD/2) clk = ~clk;

  logic rst = 1'b1, tick = 1'b0, wr_valid = 1'b0;
  logic [2:0] wr_sel = '0;
  logic [63:0] wr_data = '0;
  logic wr_ready;
  logic [63:0] phys_cnt, virt_cnt;
  logic [NCH-1:0] irq;
  logic [NCH*IDW-1:0] irq_id;

  sys_count_timer i_sys_count_timer (
    .clk(clk), .rst(rst), .tick(tick), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_sel(wr_sel), .wr_data(wr_data), .phys_cnt(phys_cnt), .virt_cnt(virt_cnt),
    .irq(irq), .irq_id(irq_id)
  );

  int checks = 0, errors = 0;
  logic [63:0] exp_phys = '0, exp_off = '0;
  int exp_id [NCH] = '{13, 10, 'h3FF, 11, 'h3FF};

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic cyc(input logic t, input logic wv, input logic [2:0] s, input logic [63:0] d);
    tick = t; wr_valid = wv; wr_sel = s; wr_data = d;
    @(posedge clk);
    @(negedge clk);
    tick = 1'b0; wr_valid = 1'b0;
    if (t) exp_phys = exp_phys + 64'd1;
    if (wv && s == 3'd5) exp_off = d;
  endtask

  function automatic logic line(input int c);
    return exp_id[c] != 'h3FF;
  endfunction

  initial begin
    #(PERIOD * 200000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    @(negedge clk); @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    chk("R1 phys", phys_cnt, 64'd0);
    chk("R1 virt", virt_cnt, 64'd0);
    chk("R1 irq", 64'(irq), 64'd0);
    for (int c = 0; c < NCH; c++) chk("R8 id", 64'(irq_id[c*IDW +: IDW]), 64'(exp_id[c]));
    chk("R10 ready", 64'(wr_ready), 64'd1);

    // R6: first tick wraps all zero channels, no pulse
    cyc(1, 0, 0, 0);
    chk("R6 wrap quiet", 64'(irq), 64'd0);
    chk("R2 step", phys_cnt, exp_phys);
    cyc(1, 0, 0, 0); cyc(1, 0, 0, 0);
    chk("R2 step3", phys_cnt, exp_phys);
    cyc(0, 0, 0, 0);
    chk("R2 hold", phys_cnt, exp_phys);

    // R3 offset
    cyc(0, 1, 5, 64'd10);
    chk("R3 virt", virt_cnt, exp_phys - exp_off);
    cyc(1, 0, 0, 0);
    chk("R3 virt tick", virt_cnt, exp_phys - exp_off);
    cyc(1, 1, 5, 64'h1234_5678_9abc_def0);
    chk("R3 offset+tick", virt_cnt, exp_phys - exp_off);
    chk("R2 offset+tick", phys_cnt, exp_phys);

    // R4/R5/R9 sweep each channel and load values
    for (int c = 0; c < NCH; c++) begin
      for (int n = 1; n <= 4; n++) begin
        cyc(0, 1, 3'(c), 64'(n));
        for (int k = 1; k <= n; k++) begin
          cyc(1, 0, 0, 0);
          chk((k == n) ? "R5 pulse" : "R4 countdown", 64'(irq),
              (k == n && line(c)) ? (64'd1 << c) : 64'd0);
        end
        cyc(1, 0, 0, 0);
        chk("R5 single cycle R6 wrap", 64'(irq), 64'd0);
        chk("R2 phys sweep", phys_cnt, exp_phys);
      end
    end

    // all channels together: R9 lineless stay low
    for (int c = 0; c < NCH; c++) cyc(0, 1, 3'(c), 64'd2);
    cyc(1, 0, 0, 0);
    chk("R4 all", 64'(irq), 64'd0);
    cyc(1, 0, 0, 0);
    chk("R9 all", 64'(irq), 64'b01011);

    // R7 write and tick in same cycle
    cyc(0, 1, 0, 64'd1);
    cyc(1, 1, 0, 64'd3);
    chk("R7 no pulse", 64'(irq), 64'd0);
    cyc(1, 0, 0, 0);
    chk("R7 after1", 64'(irq), 64'd0);
    cyc(1, 0, 0, 0);
    chk("R7 after2", 64'(irq), 64'd0);
    cyc(1, 0, 0, 0);
    chk("R7 pulse", 64'(irq), 64'd1);

    // R10 unused selects ignored
    cyc(0, 1, 1, 64'd2);
    cyc(0, 1, 6, 64'd0);
    cyc(0, 1, 7, 64'd1);
    chk("R10 offset kept", virt_cnt, exp_phys - exp_off);
    chk("R10 ready", 64'(wr_ready), 64'd1);
    cyc(1, 0, 0, 0);
    chk("R10 ch1 kept", 64'(irq), 64'd0);
    cyc(1, 0, 0, 0);
    chk("R10 ch1 pulse", 64'(irq), 64'd2);

    // R1 reset again mid-run
    rst = 1'b1;
    cyc(1, 0, 0, 0);
    rst = 1'b0;
    exp_phys = '0; exp_off = '0;
    chk("R1 phys again", phys_cnt, 64'd0);
    chk("R1 virt again", virt_cnt, 64'd0);
    cyc(1, 0, 0, 0);
    chk("R1 tv cleared", 64'(irq), 64'd0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule